// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address from a requester into a physical address through a small segment table that the operating system loads for each process. The upper bits of the logical address select one table entry. The lower bits are an offset into that segment. Each entry holds a base address, an inclusive limit, and separate read and write permission flags.

For a user-mode access, the block checks the offset against the limit and the access type against the flags. It then returns either base plus offset or a fault code. Accesses made in privileged mode skip every check and are always translated.

The table is loaded through a configuration write port. That port changes the table only while the privileged input is high. Every configuration write is acknowledged one cycle later, and a write attempted from user mode is refused with a fault code. The lookup, checks and add are combinational. The result is presented to the requester one cycle after the request, through a registered valid/fault handshake.

Top module: `sat_xlate`

## Requirements
- R1: The top 2 bits of the 14-bit logical address (`req_laddr[13:12]`) select the segment entry. The low 12 bits (`req_laddr[11:0]`) are the offset within that segment.
- R2: A legal user access returns `resp_paddr` = entry base + zero-extended offset, modulo 2^16, with `resp_fault` = 0 (none).
- R3: A user access whose offset is strictly greater than the entry limit faults with code 1 (limit), and `resp_paddr` is 0. An offset equal to the limit is legal.
- R4: A user read (`req_write`=0) to an entry with its read flag clear faults with code 2. A user write (`req_write`=1) to an entry with its write flag clear faults with code 3. A limit violation takes precedence over both, and every fault returns `resp_paddr` = 0.
- R5: A request made with `priv`=1 is never checked. It returns base + offset with `resp_fault` = 0, even beyond the limit or without permission.
- R6: A configuration write with `priv`=1 replaces the selected entry's base, limit and flags, and is acknowledged on `cfg_ack` one cycle later with `cfg_fault` = 0.
- R7: A configuration write with `priv`=0 leaves the table unchanged, and is acknowledged one cycle later with `cfg_fault` = 4 (privileged-write violation).
- R8: The response is registered. `resp_valid` rises exactly one cycle after `req_valid` is sampled high. In a cycle with no request, `resp_valid`, `resp_fault` and `resp_paddr` are all 0.
- R9: After reset, every entry has limit 0 and no permissions, so any user access faults (code 2 at offset 0 for a read, code 3 at offset 0 for a write, code 1 above offset 0). `resp_valid` and `cfg_ack` are low after reset.
- R10: A request in the same cycle as a configuration write to the same entry is translated with the entry's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv | input | 1 | Privileged mode for both request and configuration |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_laddr | input | 14 | Logical address: segment select and offset |
| resp_valid | output | 1 | Registered response valid |
| resp_fault | output | 3 | 0 none, 1 limit, 2 read, 3 write, 4 privileged-write |
| resp_paddr | output | 16 | Physical address, 0 on fault |
| cfg_we | input | 1 | Segment table write strobe |
| cfg_sel | input | 2 | Entry to write |
| cfg_base | input | 16 | New base address |
| cfg_limit | input | 12 | New inclusive limit |
| cfg_rd | input | 1 | New read permission |
| cfg_wr | input | 1 | New write permission |
| cfg_ack | output | 1 | Configuration write acknowledged |
| cfg_fault | output | 3 | 0 accepted, 4 refused from user mode |

## Verification
The hardest case to reach from the ports is a request and a configuration write to the same entry in the same cycle. That case has to show the old contents. A directed step loads a known entry and then issues a privileged rewrite together with a request whose offset is legal only under the old limit.

A second hard case is the exact limit boundary. Random offsets rarely land on it, so directed requests at offset equal to the limit and one above it cover it.

Refused user-mode writes are checked by translating through the entry afterwards and confirming that the old base still applies. Seeded random traffic mixes privileged and user table writes with requests, so all fault codes appear.

// File: rtl/sat_pkg.sv
// Package: shared fault codes and default geometry for the segmented
// address translation unit.
package sat_pkg;
    localparam int DEF_SEG_BITS = 2;
    localparam int DEF_OFF_BITS = 12;
    localparam int DEF_PA_BITS  = 16;

    // Fault cause reported with each response.
    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_LIMIT = 3'd1,
        FLT_READ  = 3'd2,
        FLT_WRITE = 3'd3,
        FLT_PRIV  = 3'd4
    } fault_e;
endpackage

// File: rtl/sat_seg_table.sv
// Module: sat_seg_table
// Holds one base/limit/permission entry per segment. Writes are accepted
// only when priv_i is high. The read port is combinational and reflects the
// contents before any write in the same cycle.
// Assumes: synchronous active-low reset; entries reset to limit 0, no access.
module sat_seg_table #(
    parameter int SEG_BITS = sat_pkg::DEF_SEG_BITS,
    parameter int OFF_BITS = sat_pkg::DEF_OFF_BITS,
    parameter int PA_BITS  = sat_pkg::DEF_PA_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                priv_i,
    input  logic                we_i,
    input  logic [SEG_BITS-1:0] wsel_i,
    input  logic [PA_BITS-1:0]  wbase_i,
    input  logic [OFF_BITS-1:0] wlimit_i,
    input  logic                wrd_i,
    input  logic                wwr_i,
    input  logic [SEG_BITS-1:0] rsel_i,
    output logic [PA_BITS-1:0]  rbase_o,
    output logic [OFF_BITS-1:0] rlimit_o,
    output logic                rrd_o,
    output logic                rwr_o
);
    localparam int NSEG = 1 << SEG_BITS;

    logic [NSEG-1:0][PA_BITS-1:0]  base_q;
    logic [NSEG-1:0][OFF_BITS-1:0] limit_q;
    logic [NSEG-1:0]               rd_q;
    logic [NSEG-1:0]               wr_q;
    logic                          accept;

    // Gate table writes on privilege.
    always_comb accept = we_i && priv_i;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        // Reset or load one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                rd_q[g]    <= 1'b0;
                wr_q[g]    <= 1'b0;
            end else if (accept && wsel_i == SEG_BITS'(g)) begin
                base_q[g]  <= wbase_i;
                limit_q[g] <= wlimit_i;
                rd_q[g]    <= wrd_i;
                wr_q[g]    <= wwr_i;
            end
        end
    end

    // Select the addressed entry for the checker.
    always_comb begin
        rbase_o  = base_q[rsel_i];
        rlimit_o = limit_q[rsel_i];
        rrd_o    = rd_q[rsel_i];
        rwr_o    = wr_q[rsel_i];
    end

    // R7: a user-mode write leaves every entry unchanged.
    a_r7_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !priv_i) |=> ($stable(base_q) && $stable(limit_q)
                               && $stable(rd_q) && $stable(wr_q)));
endmodule

// File: rtl/sat_check.sv
// Module: sat_check
// Combinational bounds and permission check plus base+offset add.
// Assumes the entry fields come from sat_seg_table. Privileged accesses skip
// all checks. The limit check outranks the permission checks.
module sat_check #(
    parameter int OFF_BITS = sat_pkg::DEF_OFF_BITS,
    parameter int PA_BITS  = sat_pkg::DEF_PA_BITS
) (
    input  logic                priv_i,
    input  logic                write_i,
    input  logic [OFF_BITS-1:0] offset_i,
    input  logic [PA_BITS-1:0]  base_i,
    input  logic [OFF_BITS-1:0] limit_i,
    input  logic                rd_ok_i,
    input  logic                wr_ok_i,
    output sat_pkg::fault_e     fault_o,
    output logic [PA_BITS-1:0]  paddr_o
);
    import sat_pkg::*;

    logic [PA_BITS-1:0] sum;

    // Relocate: base plus zero-extended offset, wrapping at PA width.
    always_comb sum = base_i + PA_BITS'(offset_i);

    // Classify the access and gate the address on a fault.
    always_comb begin
        if (priv_i)                  fault_o = FLT_NONE;
        else if (offset_i > limit_i) fault_o = FLT_LIMIT;
        else if (write_i && !wr_ok_i) fault_o = FLT_WRITE;
        else if (!write_i && !rd_ok_i) fault_o = FLT_READ;
        else                         fault_o = FLT_NONE;
        paddr_o = (fault_o == FLT_NONE) ? sum : '0;
    end
endmodule

// File: rtl/sat_xlate.sv
// Module: sat_xlate (top)
// Splits the logical address into segment and offset, looks up the table,
// checks and relocates, and registers a one-cycle response. A table write
// port is acknowledged one cycle later with an accept/refuse code.
// Assumes: synchronous active-low reset; a request sees the table as it was
// before any write in the same cycle.
module sat_xlate #(
    parameter int SEG_BITS = sat_pkg::DEF_SEG_BITS,
    parameter int OFF_BITS = sat_pkg::DEF_OFF_BITS,
    parameter int PA_BITS  = sat_pkg::DEF_PA_BITS,
    localparam int LA_BITS = SEG_BITS + OFF_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                priv,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [LA_BITS-1:0]  req_laddr,
    output logic                resp_valid,
    output logic [2:0]          resp_fault,
    output logic [PA_BITS-1:0]  resp_paddr,
    input  logic                cfg_we,
    input  logic [SEG_BITS-1:0] cfg_sel,
    input  logic [PA_BITS-1:0]  cfg_base,
    input  logic [OFF_BITS-1:0] cfg_limit,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    output logic                cfg_ack,
    output logic [2:0]          cfg_fault
);
    import sat_pkg::*;

    logic [SEG_BITS-1:0] seg;
    logic [OFF_BITS-1:0] off;
    logic [PA_BITS-1:0]  e_base;
    logic [OFF_BITS-1:0] e_limit;
    logic                e_rd, e_wr;
    fault_e              chk_fault;
    logic [PA_BITS-1:0]  chk_paddr;

    // Split the logical address into segment select and offset.
    always_comb begin
        seg = req_laddr[LA_BITS-1:OFF_BITS];
        off = req_laddr[OFF_BITS-1:0];
    end

    sat_seg_table #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_table (
        .clk(clk), .rst_n(rst_n), .priv_i(priv),
        .we_i(cfg_we), .wsel_i(cfg_sel), .wbase_i(cfg_base),
        .wlimit_i(cfg_limit), .wrd_i(cfg_rd), .wwr_i(cfg_wr),
        .rsel_i(seg), .rbase_o(e_base), .rlimit_o(e_limit),
        .rrd_o(e_rd), .rwr_o(e_wr)
    );

    sat_check #(.OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_check (
        .priv_i(priv), .write_i(req_write), .offset_i(off),
        .base_i(e_base), .limit_i(e_limit), .rd_ok_i(e_rd), .wr_ok_i(e_wr),
        .fault_o(chk_fault), .paddr_o(chk_paddr)
    );

    // Register the translation response; idle cycles return zeros.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            resp_valid <= 1'b0;
            resp_fault <= 3'd0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b1;
            resp_fault <= chk_fault;
            resp_paddr <= chk_paddr;
        end
    end

    // Acknowledge table writes with accept or refuse code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ack   <= 1'b0;
            cfg_fault <= 3'd0;
        end else begin
            cfg_ack   <= cfg_we;
            cfg_fault <= (cfg_we && !priv) ? FLT_PRIV : FLT_NONE;
        end
    end

    // R8: a response follows a request by exactly one cycle.
    a_r8_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && resp_fault == 3'd0 && resp_paddr == '0));
    // R4: any fault carries a zero physical address.
    a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 3'd0) |-> resp_paddr == '0);
    // R5: privileged requests never fault.
    a_r5_priv_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv) |=> resp_fault == 3'd0);
    // R7: refused table writes report the privileged-write code.
    a_r7_refuse_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv) |=> (cfg_ack && cfg_fault == 3'd4));
    // R6: a response never carries the table-write code.
    a_r6_resp_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault <= 3'd3);
endmodule

// File: tb/sat_xlate_test.sv
`timescale 1ns/1ps
module sat_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_laddr = '0;
    logic        resp_valid;
    logic [2:0]  resp_fault;
    logic [15:0] resp_paddr;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_base = '0;
    logic [11:0] cfg_limit = '0;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_ack;
    logic [2:0]  cfg_fault;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_base [4];
    logic [11:0] m_limit [4];
    logic        m_rd [4];
    logic        m_wr [4];

    always #2 clk = ~clk;

    sat_xlate uut (
        .clk(clk), .rst_n(rst_n), .priv(priv),
        .req_valid(req_valid), .req_write(req_write), .req_laddr(req_laddr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_ack(cfg_ack), .cfg_fault(cfg_fault)
    );

    function automatic logic [2:0] exp_fault(input logic p, input logic w, input logic [13:0] la);
        logic [1:0] s = la[13:12];
        logic [11:0] o = la[11:0];
        if (p) return 3'd0;
        if (o > m_limit[s]) return 3'd1;
        if (w && !m_wr[s]) return 3'd3;
        if (!w && !m_rd[s]) return 3'd2;
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_paddr(input logic p, input logic w, input logic [13:0] la);
        if (exp_fault(p, w, la) != 3'd0) return 16'd0;
        return m_base[la[13:12]] + {4'd0, la[11:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Issue one request; check the registered response one cycle later.
    task automatic do_req(input string req, input logic p, input logic w, input logic [13:0] la);
        logic [2:0]  ef = exp_fault(p, w, la);
        logic [15:0] ea = exp_paddr(p, w, la);
        @(negedge clk);
        priv = p; req_write = w; req_laddr = la; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; priv = 1'b0;
        check({req, " valid"}, {31'd0, resp_valid}, 32'd1);
        check({req, " fault"}, {29'd0, resp_fault}, {29'd0, ef});
        check({req, " paddr"}, {16'd0, resp_paddr}, {16'd0, ea});
    endtask

    task automatic do_cfg(input string req, input logic p, input logic [1:0] s,
                          input logic [15:0] b, input logic [11:0] l, input logic r, input logic w);
        @(negedge clk);
        priv = p; cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_limit = l; cfg_rd = r; cfg_wr = w;
        @(negedge clk);
        cfg_we = 1'b0; priv = 1'b0;
        check({req, " ack"}, {31'd0, cfg_ack}, 32'd1);
        check({req, " code"}, {29'd0, cfg_fault}, p ? 32'd0 : 32'd4);
        if (p) begin
            m_base[s] = b; m_limit[s] = l; m_rd[s] = r; m_wr[s] = w;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a7e));
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_rd[i] = 1'b0; m_wr[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        check("R9 cfg_ack after reset", {31'd0, cfg_ack}, 32'd0);
        do_req("R9 read off0", 1'b0, 1'b0, 14'h0000);
        do_req("R9 write off0", 1'b0, 1'b1, 14'h1000);
        do_req("R9 read off5", 1'b0, 1'b0, 14'h2005);
        // R8: idle cycle is quiet
        @(negedge clk);
        check("R8 idle valid", {31'd0, resp_valid}, 32'd0);
        check("R8 idle paddr", {16'd0, resp_paddr}, 32'd0);
        // R6: load table
        do_cfg("R6 load seg0", 1'b1, 2'd0, 16'h1000, 12'h0ff, 1'b1, 1'b0);
        do_cfg("R6 load seg1", 1'b1, 2'd1, 16'h4000, 12'hfff, 1'b1, 1'b1);
        do_cfg("R6 load seg2", 1'b1, 2'd2, 16'hff00, 12'h200, 1'b0, 1'b1);
        do_cfg("R6 load seg3", 1'b1, 2'd3, 16'h8000, 12'h010, 1'b1, 1'b1);
        // R1/R2: segment select and relocation, including wrap
        do_req("R1 R2 seg0 read", 1'b0, 1'b0, 14'h0042);
        do_req("R1 R2 seg1 write", 1'b0, 1'b1, 14'h1abc);
        do_req("R2 seg2 wrap write", 1'b0, 1'b1, 14'h2180);
        // R3: boundary
        do_req("R3 at limit", 1'b0, 1'b0, 14'h00ff);
        do_req("R3 above limit", 1'b0, 1'b0, 14'h0100);
        // R4: permissions and precedence
        do_req("R4 write to read-only", 1'b0, 1'b1, 14'h0010);
        do_req("R4 read of write-only", 1'b0, 1'b0, 14'h2010);
        do_req("R4 limit outranks perm", 1'b0, 1'b1, 14'h0300);
        // R5: privileged bypass
        do_req("R5 priv beyond limit", 1'b1, 1'b1, 14'h0300);
        do_req("R5 priv no read perm", 1'b1, 1'b0, 14'h2010);
        // R7: user write refused, old mapping kept
        do_cfg("R7 user write", 1'b0, 2'd1, 16'h0000, 12'h000, 1'b0, 1'b0);
        do_req("R7 seg1 unchanged", 1'b0, 1'b0, 14'h1800);
        // R10: same-cycle write and request use old entry
        @(negedge clk);
        priv = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd3; cfg_base = 16'h2000; cfg_limit = 12'h000;
        cfg_rd = 1'b0; cfg_wr = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_laddr = 14'h3008;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0; priv = 1'b0;
        check("R10 old entry paddr", {16'd0, resp_paddr}, 32'h8008);
        m_base[3] = 16'h2000; m_limit[3] = 12'h000; m_rd[3] = 1'b0; m_wr[3] = 1'b0;
        do_req("R10 new entry applies", 1'b0, 1'b0, 14'h3008);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0)
                do_cfg("R6 R7 random cfg", 1'($urandom_range(0, 1)), 2'($urandom),
                       16'($urandom), 12'($urandom_range(0, 4095)),
                       1'($urandom), 1'($urandom));
            else
                do_req("R2 R3 R4 R5 random req", ($urandom_range(0, 7) == 0),
                       1'($urandom), 14'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule